// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right frame clock for an audio serial transmitter. It runs on the master clock `clk` and divides it by two integer ratios. Each ratio is held in a configuration field as the ratio minus one. The bit clock is a level output, together with a one-cycle `bit_tick` that marks the last master cycle of each bit period. The frame clock is counted in bit periods. A `frame_start` strobe marks the first master cycle of each frame.

A host drives a single enable through three commands: start, pause and stop. Stop always halts the dividers. Pause halts them only in gated mode. In continuous mode the bit clock keeps running through a pause, so a downstream receiver never loses its clock. Both clock outputs have their own polarity invert bit. The divider fields, polarity bits and mode bit are written together, and a write is accepted only while the enable is clear. An accepted write also rewinds both dividers to the start of a frame.

Top module: `audio_sclk_gen`

## Requirements
- R1: After reset, `div_en`, `bit_tick` and `frame_start` are 0 and `bclk` and `fclk` are low. The reset configuration is: bit ratio 1 (field 0), frame ratio 64 (field 63), no inversion, gated mode.
- R2: While enabled with bit field B, `bit_tick` pulses once every B+1 master cycles. With B = 0 it is high on every enabled cycle.
- R3: Within each bit period of N = B+1 master cycles, the raw bit clock is low for the first ceil(N/2) cycles and high for the remaining floor(N/2). An odd ratio therefore gives the extra cycle to the low phase, and N = 1 leaves the raw level low.
- R4: A bit index counts bit periods modulo M = F+1, where F is the frame field. The raw frame clock is low while the index is below floor(M/2) and high otherwise. For M = 64 it toggles every 32 bit clocks.
- R5: `frame_start` is high for exactly one master cycle, while enabled, on the first master cycle of bit index 0.
- R6: A `cmd_start` pulse sets the enable. A `cmd_stop` pulse always clears it. When commands coincide, stop wins over pause and pause wins over start.
- R7: `cmd_pause` clears the enable when the mode bit `cfg_gated` is 1. When the mode bit is 0 (continuous), pause leaves the enable and the clocks untouched.
- R8: While the enable is clear, both dividers hold their position. The clock levels stay frozen and no tick or strobe is produced.
- R9: `cfg_bclk_inv` = 1 inverts `bclk` and `cfg_fclk_inv` = 1 inverts `fclk`. Each bit acts only on its own output.
- R10: A `cfg_wr` made while the enable is set is ignored entirely. A `cfg_wr` made while the enable is clear loads all fields and rewinds both dividers to bit index 0 and cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start/resume command pulse |
| cmd_pause | input | 1 | Pause command pulse |
| cmd_stop | input | 1 | Stop/suspend command pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_bclk_div | input | 6 | Master-to-bit ratio minus one |
| cfg_frame_div | input | 12 | Bit-to-frame ratio minus one |
| cfg_bclk_inv | input | 1 | Invert bit clock |
| cfg_fclk_inv | input | 1 | Invert frame clock |
| cfg_gated | input | 1 | 1 = pause stops the bit clock, 0 = continuous |
| div_en | output | 1 | Current divider enable |
| bclk | output | 1 | Bit clock level |
| fclk | output | 1 | Frame clock level |
| bit_tick | output | 1 | Last master cycle of a bit period |
| frame_start | output | 1 | First master cycle of a frame |

## Verification
A wrong position in the bit divider shows on the very next cycle as a misplaced `bit_tick` or a shifted `bclk` edge. A wrong bit index shows as an early or late `fclk` edge or `frame_start`, at the latest one frame later. A wrong enable appears on `div_en` one cycle after the command that set it, and from then on the clocks either move when they should be frozen or stay frozen when they should move. For these reasons the bench steps a behavioural model alongside the design and compares all five outputs on every master cycle. It runs through odd, even and unit ratios, pause in both modes, coinciding commands and refused writes.

// File: rtl/asg_pkg.sv
package asg_pkg;
   // Resolved effect of the command inputs on the enable
   typedef enum logic [1:0] {
      EN_KEEP = 2'd0,
      EN_SET  = 2'd1,
      EN_CLR  = 2'd2
   } en_act_e;

   localparam int POL_BCLK = 0;
   localparam int POL_FCLK = 1;
   localparam int NUM_POL  = 2;
endpackage

// File: rtl/asg_ctrl.sv
module asg_ctrl
   import asg_pkg::*;
#(
   parameter int BDIV_W   = 6,
   parameter int FDIV_W   = 12,
   parameter int RST_FDIV = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_pause,
   input  logic              cmd_stop,
   input  logic              cfg_wr,
   input  logic [BDIV_W-1:0] cfg_bdiv,
   input  logic [FDIV_W-1:0] cfg_fdiv,
   input  logic              cfg_binv,
   input  logic              cfg_finv,
   input  logic              cfg_gated,
   output logic              en_o,
   output logic              clr_o,
   output logic [BDIV_W-1:0] bdiv_o,
   output logic [FDIV_W-1:0] fdiv_o,
   output logic              binv_o,
   output logic              finv_o,
   output logic              gated_o
);
   en_act_e act;
   logic    accept;

   always_comb begin
      act = EN_KEEP;
      if (cmd_stop)                   act = EN_CLR;
      else if (cmd_pause && gated_o)  act = EN_CLR;
      else if (cmd_start)             act = EN_SET;
   end

   assign accept = cfg_wr && !en_o;
   assign clr_o  = accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o <= 1'b0;
      end else begin
         case (act)
            EN_SET:  en_o <= 1'b1;
            EN_CLR:  en_o <= 1'b0;
            default: en_o <= en_o;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bdiv_o  <= '0;
         fdiv_o  <= FDIV_W'(RST_FDIV);
         binv_o  <= 1'b0;
         finv_o  <= 1'b0;
         gated_o <= 1'b1;
      end else if (accept) begin
         bdiv_o  <= cfg_bdiv;
         fdiv_o  <= cfg_fdiv;
         binv_o  <= cfg_binv;
         finv_o  <= cfg_finv;
         gated_o <= cfg_gated;
      end
   end

   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop |=> !en_o); // R6
   AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !cmd_stop && !(cmd_pause && gated_o)) |=> en_o); // R6
   AST_CONT_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pause && !gated_o && !cmd_stop && en_o) |=> en_o); // R7
   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && en_o) |=> ($stable(bdiv_o) && $stable(fdiv_o) && $stable(gated_o))); // R10
endmodule

// File: rtl/asg_bit_div.sv
module asg_bit_div #(
   parameter int BDIV_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic [BDIV_W-1:0] bdiv,
   output logic              tick_o,
   output logic              first_o,
   output logic              level_o
);
   localparam int RW = BDIV_W + 1;

   logic [BDIV_W-1:0] cnt;
   logic [RW-1:0]     low_len;
   logic              last;

   // low phase length = ceil((bdiv+1)/2) = (bdiv+2)>>1
   assign low_len = (RW'(bdiv) + RW'(2)) >> 1;
   assign last    = (cnt == bdiv);
   assign tick_o  = en && last;
   assign first_o = (cnt == '0);
   assign level_o = (RW'(cnt) >= low_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (en)     cnt <= last ? '0 : cnt + 1'b1;
   end

   AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(cnt)); // R8
   AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && $stable(bdiv)) |=> (cnt <= bdiv)); // R2
endmodule

// File: rtl/asg_frame_div.sv
module asg_frame_div #(
   parameter int FDIV_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic              tick,
   input  logic              first,
   input  logic [FDIV_W-1:0] fdiv,
   output logic              level_o,
   output logic              fstart_o
);
   localparam int RW = FDIV_W + 1;

   logic [FDIV_W-1:0] idx;
   logic [RW-1:0]     half;

   assign half     = (RW'(fdiv) + RW'(1)) >> 1;
   assign level_o  = (RW'(idx) >= half);
   assign fstart_o = en && first && (idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (clr)    idx <= '0;
      else if (tick)   idx <= (idx == fdiv) ? '0 : idx + 1'b1;
   end

   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(idx)); // R4
   AST_FSTART_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      fstart_o |-> en); // R5
endmodule

// File: rtl/audio_sclk_gen.sv
module audio_sclk_gen
   import asg_pkg::*;
#(
   parameter int BDIV_W   = 6,
   parameter int FDIV_W   = 12,
   parameter int RST_FDIV = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_pause,
   input  logic              cmd_stop,
   input  logic              cfg_wr,
   input  logic [BDIV_W-1:0] cfg_bclk_div,
   input  logic [FDIV_W-1:0] cfg_frame_div,
   input  logic              cfg_bclk_inv,
   input  logic              cfg_fclk_inv,
   input  logic              cfg_gated,
   output logic              div_en,
   output logic              bclk,
   output logic              fclk,
   output logic              bit_tick,
   output logic              frame_start
);
   if (BDIV_W < 1 || BDIV_W > 16) begin : g_bad_bdiv
      $error("BDIV_W out of range");
   end
   if (FDIV_W < 2 || FDIV_W > 24) begin : g_bad_fdiv
      $error("FDIV_W out of range");
   end
   if (RST_FDIV < 1 || RST_FDIV >= (1 << FDIV_W)) begin : g_bad_rst
      $error("RST_FDIV does not fit FDIV_W");
   end

   logic              en, clr, tick, first, gated;
   logic [BDIV_W-1:0] bdiv;
   logic [FDIV_W-1:0] fdiv;
   logic              binv, finv;
   logic [NUM_POL-1:0] raw, inv, pol;

   asg_ctrl #(.BDIV_W(BDIV_W), .FDIV_W(FDIV_W), .RST_FDIV(RST_FDIV)) u_ctrl (
      .clk, .rst_n, .cmd_start, .cmd_pause, .cmd_stop, .cfg_wr,
      .cfg_bdiv(cfg_bclk_div), .cfg_fdiv(cfg_frame_div),
      .cfg_binv(cfg_bclk_inv), .cfg_finv(cfg_fclk_inv), .cfg_gated,
      .en_o(en), .clr_o(clr), .bdiv_o(bdiv), .fdiv_o(fdiv),
      .binv_o(binv), .finv_o(finv), .gated_o(gated)
   );

   asg_bit_div #(.BDIV_W(BDIV_W)) u_bit (
      .clk, .rst_n, .en, .clr, .bdiv,
      .tick_o(tick), .first_o(first), .level_o(raw[POL_BCLK])
   );

   asg_frame_div #(.FDIV_W(FDIV_W)) u_frame (
      .clk, .rst_n, .en, .clr, .tick, .first, .fdiv,
      .level_o(raw[POL_FCLK]), .fstart_o(frame_start)
   );

   assign inv[POL_BCLK] = binv;
   assign inv[POL_FCLK] = finv;

   for (genvar i = 0; i < NUM_POL; i++) begin : g_pol
      assign pol[i] = raw[i] ^ inv[i];
   end

   assign div_en   = en;
   assign bit_tick = tick;
   assign bclk     = pol[POL_BCLK];
   assign fclk     = pol[POL_FCLK];

   AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> div_en); // R2
   AST_FROZEN_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
      (!div_en && !cfg_wr) |=> $stable(bclk)); // R8
   AST_UNUSED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pause && gated && !cmd_start) |=> !div_en); // R7
endmodule

// File: tb/audio_sclk_gen_tb.sv
module audio_sclk_gen_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 0, rst_n = 0;
   logic cmd_start = 0, cmd_pause = 0, cmd_stop = 0, cfg_wr = 0;
   logic [5:0]  cfg_bclk_div = 0;
   logic [11:0] cfg_frame_div = 0;
   logic cfg_bclk_inv = 0, cfg_fclk_inv = 0, cfg_gated = 0;
   logic div_en, bclk, fclk, bit_tick, frame_start;

   int checks = 0, errors = 0;
   bit done = 0;
   string phase = "R1";

   // behavioural model state
   int m_en, m_n, m_m, m_cnt, m_bit, m_binv, m_finv, m_gated;

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_sclk_gen u_dut (
      .clk, .rst_n, .cmd_start, .cmd_pause, .cmd_stop, .cfg_wr,
      .cfg_bclk_div, .cfg_frame_div, .cfg_bclk_inv, .cfg_fclk_inv, .cfg_gated,
      .div_en, .bclk, .fclk, .bit_tick, .frame_start
   );

   task automatic model_reset();
      m_en = 0; m_n = 1; m_m = 64; m_cnt = 0; m_bit = 0;
      m_binv = 0; m_finv = 0; m_gated = 1;
   endtask

   task automatic model_step();
      int old_en;
      old_en = m_en;
      if (old_en != 0) begin
         if (m_cnt == m_n - 1) begin
            m_cnt = 0;
            m_bit = (m_bit == m_m - 1) ? 0 : m_bit + 1;
         end else m_cnt++;
      end
      if (cmd_stop) m_en = 0;
      else if (cmd_pause && m_gated != 0) m_en = 0;
      else if (cmd_start) m_en = 1;
      if (cfg_wr && old_en == 0) begin
         m_n = int'(cfg_bclk_div) + 1;
         m_m = int'(cfg_frame_div) + 1;
         m_binv = cfg_bclk_inv; m_finv = cfg_fclk_inv; m_gated = cfg_gated;
         m_cnt = 0; m_bit = 0;
      end
   endtask

   task automatic chk(string req, string sig, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (%s) %s: actual %0b expected %0b at %0t", req, phase, sig, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic e_b, e_f, e_t, e_s;
      e_b = ((m_cnt >= (m_n + 1) / 2) ? 1'b1 : 1'b0) ^ m_binv[0];
      e_f = ((m_bit >= m_m / 2) ? 1'b1 : 1'b0) ^ m_finv[0];
      e_t = (m_en != 0) && (m_cnt == m_n - 1);
      e_s = (m_en != 0) && (m_cnt == 0) && (m_bit == 0);
      chk("R6", "div_en", div_en, m_en[0]);
      chk("R3", "bclk", bclk, e_b);
      chk("R4", "fclk", fclk, e_f);
      chk("R2", "bit_tick", bit_tick, e_t);
      chk("R5", "frame_start", frame_start, e_s);
   endtask

   // one master cycle: model follows the edge, outputs compared mid-cycle
   task automatic step();
      @(posedge clk);
      if (rst_n) model_step(); else model_reset();
      @(negedge clk);
      compare();
      cmd_start = 0; cmd_pause = 0; cmd_stop = 0; cfg_wr = 0;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic write_cfg(int b, int f, bit bi, bit fi, bit g);
      cfg_wr = 1; cfg_bclk_div = 6'(b); cfg_frame_div = 12'(f);
      cfg_bclk_inv = bi; cfg_fclk_inv = fi; cfg_gated = g;
      step();
   endtask

   task automatic cmd(bit s, bit p, bit t);
      cmd_start = s; cmd_pause = p; cmd_stop = t;
      step();
   endtask

   initial begin
      model_reset();
      @(negedge clk);
      phase = "R1";
      compare();
      rst_n = 1;
      run(3);

      phase = "R2";           // even ratio 4, 64-bit frame
      write_cfg(3, 63, 0, 0, 1);
      cmd(1, 0, 0);
      run(600);

      phase = "R8";           // gated pause freezes everything
      cmd(0, 1, 0);
      chk("R8", "div_en after gated pause", div_en, 1'b0);
      run(20);

      phase = "R10";          // write while disabled rewinds, odd ratio 5, frame 8
      write_cfg(4, 7, 0, 0, 0);
      cmd(1, 0, 0);
      run(200);

      phase = "R10";          // write while enabled is refused
      write_cfg(0, 3, 1, 1, 1);
      run(120);

      phase = "R7";           // continuous mode: pause has no effect
      cmd(0, 1, 0);
      chk("R7", "div_en after continuous pause", div_en, 1'b1);
      run(60);

      phase = "R6";           // stop always halts, even in continuous mode
      cmd(0, 0, 1);
      chk("R6", "div_en after stop", div_en, 1'b0);
      run(10);

      phase = "R9";           // ratio 1, frame 4, both clocks inverted
      write_cfg(0, 3, 1, 1, 1);
      cmd(1, 0, 0);
      run(40);

      phase = "R6";           // coinciding commands: stop beats start
      cmd(1, 1, 1);
      chk("R6", "stop over start", div_en, 1'b0);
      cmd(1, 0, 0);
      phase = "R7";           // gated pause beats start
      cmd(1, 1, 0);
      chk("R7", "pause over start", div_en, 1'b0);
      run(5);

      phase = "R9";           // only bit clock inverted, ratio 3, frame 6
      write_cfg(2, 5, 1, 0, 1);
      cmd(1, 0, 0);
      run(150);

      phase = "R3";           // ratio 2, frame 2
      cmd(0, 0, 1);
      write_cfg(1, 1, 0, 1, 1);
      cmd(1, 0, 0);
      run(40);

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog (%s): actual hung expected finished", phase);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule